// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block puts one packet onto the differential pair of a low-speed USB device. The caller gives a byte count and then supplies the bytes one at a time. The first byte must be the sync pattern, and the count includes it. Each byte goes out least significant bit first, with bit stuffing and NRZI coding, at a rate set by a one-cycle enable that pulses once per bit period. After the last bit the block closes the packet with an end-of-packet sequence, turns both line drivers off and pulses a completion flag.

A second request input sends a two-byte handshake without any byte stream from the caller. The block makes the sync byte and the accept or reject identifier itself. The block also holds the active device address. An address waiting on its input is copied into that register when a data packet completes. It is not copied when a handshake completes, so a new address only takes effect after the status reply that carried it has gone out.

Top module: `usb_ls_tx`

## Requirements
- R1: While reset is held, and while idle afterwards, both output enables are low, both lines are driven low, `tx_busy` and `tx_done` are low, `tx_ready` is low and `dev_addr` is zero.
- R2: One clock after an accepted request, `tx_busy` is high and both enables are high with the idle J state on the lines (`dp`=0, `dm`=1). J holds until the first `bit_en` that follows the request.
- R3: The line symbol is {`dp`,`dm`}: J is 01, K is 10 and SE0 is 00. A 0 data bit flips the line between J and K. A 1 data bit leaves it unchanged.
- R4: Bytes are sent in order, bit 0 first, until `tx_count` bytes have gone out; the count includes the sync byte. `tx_ready` is high for exactly one clock per byte. That clock is the `bit_en` cycle in which the byte's first bit is launched, and `tx_data` is taken in that same cycle.
- R5: A run counter is set to 6 whenever the line flips and goes down by one for each 1 bit. When it reaches zero, an extra flip is sent before the next data bit, or before end of packet if no data bit remains.
- R6: Every symbol, stuffed ones included, holds for exactly one bit period. The lines change only on the clock that follows a cycle with `bit_en` high.
- R7: After the last symbol the lines show SE0 for two bit periods and then J for one. On the clock after the `bit_en` that ends the J period, both enables and both lines go low, `tx_busy` falls, and `tx_done` is high for one clock.
- R8: `hs_start` sends sync 0x80 followed by 0xD2 when `hs_ack` is 1, or by 0x5A when `hs_ack` is 0, and raises no `tx_ready`.
- R9: On the `tx_done` clock of a data packet, `dev_addr` takes the value of `new_addr`. After a handshake packet `dev_addr` keeps its value. `dev_addr` changes at no other time.
- R10: `tx_start`, `hs_start` and `tx_count` are ignored while `tx_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit period |
| tx_start | input | 1 | Request a data packet (priority over hs_start) |
| tx_count | input | CNT_W | Bytes in the packet, sync byte included |
| tx_ready | output | 1 | Byte on tx_data is taken this cycle |
| tx_data | input | BYTE_W | Next packet byte |
| hs_start | input | 1 | Request a handshake packet |
| hs_ack | input | 1 | 1 selects accept identifier, 0 selects reject |
| new_addr | input | ADDR_W | Address to adopt after the next data packet |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| dp_oe | output | 1 | D+ driver enable |
| dm_oe | output | 1 | D- driver enable |
| tx_busy | output | 1 | A packet is in progress |
| tx_done | output | 1 | One-clock pulse when the bus is released |
| dev_addr | output | ADDR_W | Active device address |

## Verification
A request shows on the lines one clock after it is accepted. Each later symbol appears on the clock after the `bit_en` cycle that launches it, and `tx_ready` is high within that `bit_en` cycle. The release, the `tx_done` pulse and the address update all land on the clock after the `bit_en` that ends the closing J period. The bench builds the full expected symbol list from the packet bytes. It drives inputs and samples outputs on falling edges. At each falling edge where `bit_en` is high it checks that the previous symbol still holds. At the falling edge one clock later it checks the new symbol, so both the value of every symbol and its exact position in time are checked.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

   // line symbol as {dp, dm}
   typedef enum logic [1:0] {
      LINE_SE0 = 2'b00,
      LINE_J   = 2'b01,
      LINE_K   = 2'b10
   } line_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_SEND,
      ST_SE0_1,
      ST_SE0_2,
      ST_EOP_J
   } tx_state_t;

   function automatic line_t line_flip(input line_t l);
      return (l == LINE_J) ? LINE_K : LINE_J;
   endfunction

endpackage

// File: rtl/usb_ls_tx_src.sv
// Byte supply: counts packet bytes and selects the caller stream or the
// internally built handshake bytes.
module usb_ls_tx_src
   import usb_ls_tx_pkg::*;
#(
   parameter int                BYTE_W  = 8,
   parameter int                CNT_W   = 8,
   parameter logic [BYTE_W-1:0] PID_ACK = 8'hD2,
   parameter logic [BYTE_W-1:0] PID_NAK = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_hs,
   input  logic              load_ack,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              take,
   input  logic [BYTE_W-1:0] ext_byte,
   output logic [BYTE_W-1:0] byte_out,
   output logic              have_byte,
   output logic              ext_ready
);

   localparam logic [BYTE_W-1:0] SYNC_PAT = BYTE_W'(1) << (BYTE_W - 1);
   localparam logic [CNT_W-1:0]  HS_LEN   = CNT_W'(2);

   logic [CNT_W-1:0]  left_q;
   logic              hs_q;
   logic              ack_q;
   logic [BYTE_W-1:0] hs_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         hs_q   <= 1'b0;
         ack_q  <= 1'b0;
      end else if (load) begin
         left_q <= load_hs ? HS_LEN : load_cnt;
         hs_q   <= load_hs;
         ack_q  <= load_ack;
      end else if (take && have_byte) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign have_byte = (left_q != '0);
   assign hs_byte   = (left_q == HS_LEN) ? SYNC_PAT : (ack_q ? PID_ACK : PID_NAK);
   assign byte_out  = hs_q ? hs_byte : ext_byte;
   assign ext_ready = take && have_byte && !hs_q;

endmodule

// File: rtl/usb_ls_tx_enc.sv
// Serializer: bit order, stuffing and NRZI line state.
module usb_ls_tx_enc
   import usb_ls_tx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int STUFF_RUN = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              step,
   input  logic              have_byte,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              take,
   output logic              drained,
   output line_t             sym
);

   localparam int BC_W  = $clog2(BYTE_W + 1);
   localparam int RUN_W = $clog2(STUFF_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_LOAD = RUN_W'(STUFF_RUN);
   localparam logic [BC_W-1:0]  BIT_LOAD = BC_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh_q;
   logic [BC_W-1:0]   bits_q;
   logic [RUN_W-1:0]  run_q;
   line_t             sym_q;

   logic stuff_now;
   logic in_byte;
   logic cur_bit;
   logic bit_go;

   always_comb begin
      stuff_now = (run_q == '0);
      in_byte   = (bits_q != '0);
      cur_bit   = in_byte ? sh_q[0] : byte_in[0];
      bit_go    = step && !stuff_now && (in_byte || have_byte);
   end

   assign take    = step && !stuff_now && !in_byte && have_byte;
   assign drained = !stuff_now && !in_byte && !have_byte;
   assign sym     = sym_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bits_q <= '0;
         run_q  <= RUN_LOAD;
         sym_q  <= LINE_J;
      end else if (init) begin
         sh_q   <= '0;
         bits_q <= '0;
         run_q  <= RUN_LOAD;
         sym_q  <= LINE_J;
      end else if (step && stuff_now) begin
         sym_q <= line_flip(sym_q);
         run_q <= RUN_LOAD;
      end else if (bit_go) begin
         if (in_byte) begin
            sh_q   <= sh_q >> 1;
            bits_q <= bits_q - BC_W'(1);
         end else begin
            sh_q   <= byte_in >> 1;
            bits_q <= BIT_LOAD;
         end
         if (!cur_bit) begin
            sym_q <= line_flip(sym_q);
            run_q <= RUN_LOAD;
         end else begin
            run_q <= run_q - RUN_W'(1);
         end
      end
   end

   AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && stuff_now) |=> (sym_q != $past(sym_q)))
      else $error("stuffed symbol did not flip the line"); // R5

   AST_SYM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !init) |=> $stable(sym_q))
      else $error("line symbol moved without a bit step"); // R6

endmodule

// File: rtl/usb_ls_tx_seq.sv
// Packet sequencer: arming, end-of-packet, release and address commit.
module usb_ls_tx_seq
   import usb_ls_tx_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              req_data,
   input  logic              req_hs,
   input  logic              drained,
   input  line_t             sym,
   input  logic [ADDR_W-1:0] new_addr,
   output logic              accept,
   output logic              step,
   output line_t             line,
   output logic              drive,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] addr
);

   tx_state_t         st_q;
   logic              data_q;
   logic              done_q;
   logic [ADDR_W-1:0] addr_q;

   assign accept = (st_q == ST_IDLE) && (req_data || req_hs);
   assign step   = bit_en && ((st_q == ST_ARM) || (st_q == ST_SEND));
   assign busy   = (st_q != ST_IDLE);
   assign done   = done_q;
   assign addr   = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         data_q <= 1'b0;
         done_q <= 1'b0;
         addr_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  st_q   <= ST_ARM;
                  data_q <= req_data;
               end
            end
            ST_ARM, ST_SEND: begin
               if (bit_en) st_q <= drained ? ST_SE0_1 : ST_SEND;
            end
            ST_SE0_1: begin
               if (bit_en) st_q <= ST_SE0_2;
            end
            ST_SE0_2: begin
               if (bit_en) st_q <= ST_EOP_J;
            end
            ST_EOP_J: begin
               if (bit_en) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  if (data_q) addr_q <= new_addr;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_ARM:             begin line = LINE_J;   drive = 1'b1; end
         ST_SEND:            begin line = sym;      drive = 1'b1; end
         ST_SE0_1, ST_SE0_2: begin line = LINE_SE0; drive = 1'b1; end
         ST_EOP_J:           begin line = LINE_J;   drive = 1'b1; end
         default:            begin line = LINE_SE0; drive = 1'b0; end
      endcase
   end

   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!drive && line == LINE_SE0))
      else $error("bus still driven at completion"); // R7

   AST_ADDR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> done_q)
      else $error("address changed outside completion"); // R9

   AST_HS_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !data_q) |-> $stable(addr_q))
      else $error("handshake changed the address"); // R9

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
   import usb_ls_tx_pkg::*;
#(
   parameter int                BYTE_W    = 8,
   parameter int                CNT_W     = 8,
   parameter int                ADDR_W    = 7,
   parameter int                STUFF_RUN = 6,
   parameter bit                HS_EN     = 1'b1,
   parameter logic [BYTE_W-1:0] PID_ACK   = 8'hD2,
   parameter logic [BYTE_W-1:0] PID_NAK   = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              tx_start,
   input  logic [CNT_W-1:0]  tx_count,
   output logic              tx_ready,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              hs_start,
   input  logic              hs_ack,
   input  logic [ADDR_W-1:0] new_addr,
   output logic              dp,
   output logic              dm,
   output logic              dp_oe,
   output logic              dm_oe,
   output logic              tx_busy,
   output logic              tx_done,
   output logic [ADDR_W-1:0] dev_addr
);

   if (BYTE_W < 2) begin : g_chk_byte
      $error("BYTE_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end
   if (STUFF_RUN < 1) begin : g_chk_run
      $error("STUFF_RUN must be at least 1");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("ADDR_W must be at least 1");
   end

   logic              hs_req;
   logic              accept;
   logic              step;
   logic              take;
   logic              drained;
   logic              have_byte;
   logic [BYTE_W-1:0] cur_byte;
   line_t             enc_sym;
   line_t             bus_line;
   logic              drive;

   if (HS_EN) begin : g_hs_on
      assign hs_req = hs_start;
   end else begin : g_hs_off
      assign hs_req = 1'b0;
   end

   usb_ls_tx_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .req_data (tx_start),
      .req_hs   (hs_req),
      .drained  (drained),
      .sym      (enc_sym),
      .new_addr (new_addr),
      .accept   (accept),
      .step     (step),
      .line     (bus_line),
      .drive    (drive),
      .busy     (tx_busy),
      .done     (tx_done),
      .addr     (dev_addr)
   );

   usb_ls_tx_src #(
      .BYTE_W  (BYTE_W),
      .CNT_W   (CNT_W),
      .PID_ACK (PID_ACK),
      .PID_NAK (PID_NAK)
   ) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_hs   (!tx_start),
      .load_ack  (hs_ack),
      .load_cnt  (tx_count),
      .take      (take),
      .ext_byte  (tx_data),
      .byte_out  (cur_byte),
      .have_byte (have_byte),
      .ext_ready (tx_ready)
   );

   usb_ls_tx_enc #(
      .BYTE_W    (BYTE_W),
      .STUFF_RUN (STUFF_RUN)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (accept),
      .step      (step),
      .have_byte (have_byte),
      .byte_in   (cur_byte),
      .take      (take),
      .drained   (drained),
      .sym       (enc_sym)
   );

   assign dp    = bus_line[1];
   assign dm    = bus_line[0];
   assign dp_oe = drive;
   assign dm_oe = drive;

   AST_READY_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> bit_en)
      else $error("byte fetched outside a bit step"); // R4

   AST_LINE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_oe && $past(dp_oe) && !$stable({dp, dm})) |-> $past(bit_en))
      else $error("line changed without bit enable"); // R6

endmodule

// File: tb/usb_ls_tx_test.sv
module usb_ls_tx_test;

   localparam int CLK_P   = 10;
   localparam int BIT_DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       tx_start;
   logic [7:0] tx_count;
   logic       tx_ready;
   logic [7:0] tx_data;
   logic       hs_start;
   logic       hs_ack;
   logic [6:0] new_addr;
   logic       dp, dm, dp_oe, dm_oe;
   logic       tx_busy, tx_done;
   logic [6:0] dev_addr;

   int checks = 0;
   int errors = 0;

   logic [7:0] pkt [0:15];
   int         fetch_idx;
   int         fetch_base = 0;
   logic [1:0] ex_line [0:511];
   int         ex_n;

   always #(CLK_P/2) clk = ~clk;

   usb_ls_tx uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .tx_start(tx_start), .tx_count(tx_count), .tx_ready(tx_ready), .tx_data(tx_data),
      .hs_start(hs_start), .hs_ack(hs_ack), .new_addr(new_addr),
      .dp(dp), .dm(dm), .dp_oe(dp_oe), .dm_oe(dm_oe),
      .tx_busy(tx_busy), .tx_done(tx_done), .dev_addr(dev_addr)
   );

   assign tx_data = pkt[(fetch_idx - fetch_base) & 15];

   // bit period strobe, updated after the edge that samples it
   initial begin
      int div;
      div = 0;
      bit_en = 1'b0;
      forever begin
         @(posedge clk);
         div = (div + 1) % BIT_DIV;
         bit_en <= (div == 0);
      end
   end

   // counts bytes handed over on tx_ready
   initial begin
      fetch_idx = 0;
      forever begin
         @(posedge clk);
         if (tx_ready === 1'b1) fetch_idx <= fetch_idx + 1;
      end
   end

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] lv);
      ex_line[ex_n] = lv;
      ex_n = ex_n + 1;
   endtask

   // expected symbol list from R2, R3, R5, R7
   task automatic build_expect(input int nb);
      logic [1:0] lv;
      int run;
      ex_n = 0;
      lv = 2'b01;
      push(lv);
      run = 6;
      for (int b = 0; b < nb; b++) begin
         for (int i = 0; i < 8; i++) begin
            if (run == 0) begin lv = ~lv; push(lv); run = 6; end
            if (pkt[b][i] == 1'b0) begin lv = ~lv; run = 6; end
            else run = run - 1;
            push(lv);
         end
      end
      if (run == 0) begin lv = ~lv; push(lv); end
      push(2'b00);
      push(2'b00);
      push(2'b01);
   endtask

   task automatic wait_bit();
      while (bit_en !== 1'b1) @(negedge clk);
   endtask

   task automatic run_packet(input string req, input int nb, input logic hs,
                             input logic ack, input logic inject);
      logic [6:0] addr_before;
      addr_before = dev_addr;
      build_expect(nb);
      @(negedge clk);
      fetch_base = fetch_idx;
      tx_count = 8'(nb);
      hs_ack = ack;
      if (hs) hs_start = 1'b1; else tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      hs_start = 1'b0;
      chk("R2", "busy after request", 32'(tx_busy), 32'd1);
      chk("R2", "idle J after request", 32'({dp_oe, dm_oe, dp, dm}), 32'({2'b11, ex_line[0]}));
      for (int k = 1; k < ex_n; k++) begin
         wait_bit();
         chk("R6", "symbol held for its period", 32'({dp_oe, dm_oe, dp, dm}), 32'({2'b11, ex_line[k-1]}));
         @(negedge clk);
         chk(req, "line symbol", 32'({dp_oe, dm_oe, dp, dm}), 32'({2'b11, ex_line[k]}));
         if (inject && k == 4) begin
            tx_start = 1'b1;
            hs_start = 1'b1;
            tx_count = 8'd1;
            @(negedge clk);
            tx_start = 1'b0;
            hs_start = 1'b0;
         end
      end
      wait_bit();
      chk("R7", "closing J held", 32'({dp_oe, dm_oe, dp, dm}), 32'b1101);
      @(negedge clk);
      chk("R7", "bus released", 32'({dp_oe, dm_oe, dp, dm}), 32'b0000);
      chk("R7", "done pulse", 32'(tx_done), 32'd1);
      chk("R7", "busy cleared", 32'(tx_busy), 32'd0);
      chk("R9", "address after packet", 32'(dev_addr), hs ? 32'(addr_before) : 32'(new_addr));
      chk(hs ? "R8" : "R4", "bytes fetched", 32'(fetch_idx - fetch_base), hs ? 32'd0 : 32'(nb));
      @(negedge clk);
      chk("R7", "done one clock", 32'(tx_done), 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tx_start = 1'b0; hs_start = 1'b0; hs_ack = 1'b0;
      tx_count = 8'd0; new_addr = 7'h00;
      repeat (4) @(negedge clk);
      chk("R1", "lines in reset", 32'({dp_oe, dm_oe, dp, dm}), 32'd0);
      chk("R1", "busy/done/ready in reset", 32'({tx_busy, tx_done, tx_ready}), 32'd0);
      chk("R1", "address in reset", 32'(dev_addr), 32'd0);
      rst_n = 1'b1;
      repeat (2 * BIT_DIV) @(negedge clk);
      chk("R1", "idle lines", 32'({dp_oe, dm_oe, dp, dm}), 32'd0);
      chk("R1", "idle busy/ready", 32'({tx_busy, tx_ready}), 32'd0);
   endtask

   task automatic t_data_mixed();
      pkt[0] = 8'h80; pkt[1] = 8'hC3; pkt[2] = 8'h5A;
      new_addr = 7'h15;
      run_packet("R3", 3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_stuff_at_end();
      pkt[0] = 8'h80; pkt[1] = 8'hFC;
      new_addr = 7'h2A;
      run_packet("R5", 2, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_stuff_long();
      pkt[0] = 8'h80; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h00;
      new_addr = 7'h41;
      run_packet("R5", 4, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_handshake(input logic ack);
      pkt[0] = 8'h80;
      pkt[1] = ack ? 8'hD2 : 8'h5A;
      new_addr = 7'h7F;
      run_packet("R8", 2, 1'b1, ack, 1'b0);
   endtask

   task automatic t_busy_ignored();
      pkt[0] = 8'h80; pkt[1] = 8'h12; pkt[2] = 8'h34;
      new_addr = 7'h05;
      run_packet("R10", 3, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_sync_only();
      pkt[0] = 8'h80;
      new_addr = 7'h3C;
      run_packet("R4", 1, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_data_mixed();
      t_stuff_at_end();
      t_stuff_long();
      t_handshake(1'b1);
      t_handshake(1'b0);
      t_busy_ignored();
      t_sync_only();
      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule